// File: doc/BRIEF.md
# Byte-Wide Passive Configuration Loader

This block is the host side of a byte-parallel passive configuration link. It takes a configuration image from a valid/ready byte stream and clocks it into a programmable device. The image is of the kind that the device expands or decrypts on the fly, so each byte must stay on the bus for four configuration clock periods. A controller pulses `start`. The block then asserts the active-low configuration request and waits for the device's active-low status pin to release. It streams the bytes and keeps clocking until the device signals that it has accepted the image. After that it sends the trailing initialization clocks and reports `done`, or it reports one of two error flags.

The configuration clock is derived from the system clock by a divider that software can set (`half_period` system cycles per clock phase). The bus byte only changes while that clock is low. When the stream runs dry the clock is parked low and the byte is held. The three device pins are brought into the system clock domain by a synchronizer before any decision uses them.

Top module: `pp_cfg_host`

## Requirements
- R1: While reset is asserted, `dev_config_n` is 1, `dev_clk` is 0, `dev_data` is 0, and `s_ready`, `busy`, `done`, `err_status` and `err_timeout` are all 0.
- R2: A `start` pulse seen while idle or done drives `dev_config_n` low for exactly PULSE_CYC (default 8) system cycles. It then releases it high and clears both error flags.
- R3: No `dev_clk` rising edge and no `s_ready` occur until `dev_status_n`, seen through the SYNC_STAGES-deep (default 2) synchronizer, is high after the request pulse.
- R4: Each accepted byte stays on `dev_data` for exactly CLKS_PER_BYTE (default 4) consecutive `dev_clk` rising edges. `dev_data` only changes in a cycle where `dev_clk` is low and was low in the previous cycle.
- R5: Every high phase of `dev_clk` lasts exactly `half_period` system cycles. Every low phase lasts at least that long.
- R6: While no byte is held (`s_ready` high), `dev_clk` stays low and `dev_data` keeps its last value.
- R7: After the byte flagged `s_last` has had its clocks, `dev_clk` keeps running. Once the synchronized `dev_cfg_done` has been registered high, exactly TAIL_FALLS (default 2) more falling edges are produced, and `dev_clk` is then held low.
- R8: The `wait_init` value sampled at `start` selects the ending. With 1, `done` rises only after the synchronized `dev_init_done` is high. With 0, `done` rises right after the trailing clocks.
- R9: If the synchronized `dev_status_n` is low while streaming or trailing, `err_status` is set, the block returns to idle, `busy` drops and `dev_clk` goes low.
- R10: If `tmo_limit` falling edges of `dev_clk` occur after the last byte with `dev_cfg_done` not yet registered, `err_timeout` is set and the block returns to idle.
- R11: After either error, a new `start` runs a full fresh load that can end in `done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a configuration run (idle or done only) |
| wait_init | input | 1 | Wait for device initialization before done |
| half_period | input | HALF_W | System cycles per configuration clock phase (>=1) |
| tmo_limit | input | TMO_W | Trailing clock budget for the accept flag (>=1) |
| s_valid | input | 1 | Stream byte valid |
| s_data | input | 8 | Stream byte |
| s_last | input | 1 | Marks the final byte of the image |
| s_ready | output | 1 | Block takes the byte this cycle |
| dev_config_n | output | 1 | Active-low configuration request |
| dev_clk | output | 1 | Configuration clock |
| dev_data | output | 8 | Configuration byte bus |
| dev_status_n | input | 1 | Device status, low while in reset or on error |
| dev_cfg_done | input | 1 | Device has accepted the image |
| dev_init_done | input | 1 | Device initialization finished |
| busy | output | 1 | A run is in progress |
| done | output | 1 | Run finished successfully |
| err_status | output | 1 | Device status dropped mid-load |
| err_timeout | output | 1 | Accept flag never arrived |

## Verification
The bench runs a clock-accurate behavioural model next to the block and compares it on every cycle. A device model answers the pins, and a stream source stalls on a pattern. It runs clock rates from one to three system cycles per phase and drops status in the middle of a byte. It also withholds the accept flag altogether and restarts after a failure. If the per-byte count were off, the device would capture a byte three or five times. If data were updated on the wrong phase, it would change while the clock was high. If the trailing counter were wrong, the clock would stop one falling edge early or run on after `done`. If a sticky error were not cleared on restart, the recovery run would still report failure.

// File: rtl/pp_cfg_pkg.sv
package pp_cfg_pkg;

    localparam int BYTE_W = 8;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PULSE,
        ST_WAIT_STAT,
        ST_STREAM,
        ST_TAIL,
        ST_WAIT_INIT,
        ST_DONE
    } host_st_e;

endpackage

// File: rtl/pp_pin_sync.sv
module pp_pin_sync #(
    parameter int W      = 3,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] pin_i,
    output logic [W-1:0] pin_s
);
    logic [W-1:0] stg_q [STAGES];

    for (genvar g = 0; g < STAGES; g++) begin : g_stage
        if (g == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) stg_q[g] <= '0;
                else        stg_q[g] <= pin_i;
            end
        end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) stg_q[g] <= '0;
                else        stg_q[g] <= stg_q[g-1];
            end
        end
    end

    assign pin_s = stg_q[STAGES-1];
endmodule

// File: rtl/pp_dclk_gen.sv
module pp_dclk_gen #(
    parameter int HALF_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run,
    input  logic [HALF_W-1:0] half_period,
    output logic              level,
    output logic              fall_next
);
    typedef struct packed {
        logic [HALF_W-1:0] cnt;
        logic              lvl;
    } gen_t;

    gen_t q, d;
    logic [HALF_W-1:0] term;

    assign term = (half_period == '0) ? '0 : half_period - HALF_W'(1);

    always_comb begin
        d = q;
        if (!run) begin
            d.cnt = '0;
            d.lvl = 1'b0;
        end else if (q.cnt == term) begin
            d.cnt = '0;
            d.lvl = ~q.lvl;
        end else begin
            d.cnt = q.cnt + HALF_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign level     = q.lvl;
    assign fall_next = run && q.lvl && (q.cnt == term);
endmodule

// File: rtl/pp_cfg_host.sv
module pp_cfg_host
    import pp_cfg_pkg::*;
#(
    parameter int HALF_W        = 8,
    parameter int TMO_W         = 16,
    parameter int PULSE_CYC     = 8,
    parameter int CLKS_PER_BYTE = 4,
    parameter int TAIL_FALLS    = 2,
    parameter int SYNC_STAGES   = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              wait_init,
    input  logic [HALF_W-1:0] half_period,
    input  logic [TMO_W-1:0]  tmo_limit,
    input  logic              s_valid,
    input  logic [BYTE_W-1:0] s_data,
    input  logic              s_last,
    output logic              s_ready,
    output logic              dev_config_n,
    output logic              dev_clk,
    output logic [BYTE_W-1:0] dev_data,
    input  logic              dev_status_n,
    input  logic              dev_cfg_done,
    input  logic              dev_init_done,
    output logic              busy,
    output logic              done,
    output logic              err_status,
    output logic              err_timeout
);
    localparam int PC_W   = $clog2(PULSE_CYC + 1);
    localparam int IDX_W  = $clog2(CLKS_PER_BYTE + 1);
    localparam int TAIL_W = $clog2(TAIL_FALLS + 1);

    typedef struct packed {
        host_st_e          st;
        logic [PC_W-1:0]   pcnt;
        logic              have;
        logic [IDX_W-1:0]  idx;
        logic              last;
        logic [BYTE_W-1:0] data;
        logic              seen;
        logic [TAIL_W-1:0] tcnt;
        logic [TMO_W-1:0]  tmo;
        logic              err_st;
        logic              err_to;
        logic              wait_init;
    } regs_t;

    regs_t q, d;

    logic [2:0] pins_s;
    logic       stat_s, cdone_s, init_s;
    logic       run, lvl, fall;

    pp_pin_sync #(.W(3), .STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .pin_i ({dev_status_n, dev_cfg_done, dev_init_done}),
        .pin_s (pins_s)
    );

    assign stat_s  = pins_s[2];
    assign cdone_s = pins_s[1];
    assign init_s  = pins_s[0];

    assign run = (((q.st == ST_STREAM) && q.have) || (q.st == ST_TAIL)) && stat_s;

    pp_dclk_gen #(.HALF_W(HALF_W)) u_gen (
        .clk         (clk),
        .rst_n       (rst_n),
        .run         (run),
        .half_period (half_period),
        .level       (lvl),
        .fall_next   (fall)
    );

    always_comb begin
        d = q;
        unique case (q.st)
            ST_IDLE, ST_DONE: begin
                if (start) begin
                    d.st        = ST_PULSE;
                    d.pcnt      = '0;
                    d.have      = 1'b0;
                    d.idx       = '0;
                    d.seen      = 1'b0;
                    d.tcnt      = '0;
                    d.tmo       = '0;
                    d.err_st    = 1'b0;
                    d.err_to    = 1'b0;
                    d.wait_init = wait_init;
                end
            end
            ST_PULSE: begin
                if (q.pcnt == PC_W'(PULSE_CYC - 1)) d.st = ST_WAIT_STAT;
                else                                d.pcnt = q.pcnt + PC_W'(1);
            end
            ST_WAIT_STAT: begin
                if (stat_s) d.st = ST_STREAM;
            end
            ST_STREAM: begin
                if (!stat_s) begin
                    d.st     = ST_IDLE;
                    d.err_st = 1'b1;
                    d.have   = 1'b0;
                end else begin
                    if (cdone_s) d.seen = 1'b1;
                    if (!q.have && s_valid) begin
                        d.have = 1'b1;
                        d.data = s_data;
                        d.last = s_last;
                        d.idx  = '0;
                    end
                    if (fall) begin
                        if (q.idx == IDX_W'(CLKS_PER_BYTE - 1)) begin
                            d.have = 1'b0;
                            if (q.last) d.st = ST_TAIL;
                        end else begin
                            d.idx = q.idx + IDX_W'(1);
                        end
                    end
                end
            end
            ST_TAIL: begin
                if (!stat_s) begin
                    d.st     = ST_IDLE;
                    d.err_st = 1'b1;
                end else begin
                    if (cdone_s) d.seen = 1'b1;
                    if (fall) begin
                        if (q.seen) begin
                            if (q.tcnt == TAIL_W'(TAIL_FALLS - 1))
                                d.st = q.wait_init ? ST_WAIT_INIT : ST_DONE;
                            else
                                d.tcnt = q.tcnt + TAIL_W'(1);
                        end else if (q.tmo == tmo_limit - TMO_W'(1)) begin
                            d.err_to = 1'b1;
                            d.st     = ST_IDLE;
                        end else begin
                            d.tmo = q.tmo + TMO_W'(1);
                        end
                    end
                end
            end
            ST_WAIT_INIT: begin
                if (init_s) d.st = ST_DONE;
            end
            default: d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '{st: ST_IDLE, default: '0};
        else        q <= d;
    end

    assign s_ready      = (q.st == ST_STREAM) && !q.have && stat_s;
    assign dev_config_n = (q.st != ST_PULSE);
    assign dev_clk      = lvl;
    assign dev_data     = q.data;
    assign busy         = (q.st != ST_IDLE) && (q.st != ST_DONE);
    assign done         = (q.st == ST_DONE);
    assign err_status   = q.err_st;
    assign err_timeout  = q.err_to;
endmodule

// File: rtl/pp_cfg_host_chk.sv
module pp_cfg_host_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       start,
    input logic       dev_config_n,
    input logic       dev_clk,
    input logic [7:0] dev_data,
    input logic       s_ready,
    input logic       busy,
    input logic       err_status,
    input logic       err_timeout,
    input logic       stat_s
);
    assert_pulse_needs_start_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(dev_config_n) |-> $past(start));

    assert_clk_after_status_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(dev_clk) |-> $past(stat_s));

    assert_data_moves_low_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(dev_data) |-> (!dev_clk && !$past(dev_clk)));

    assert_parked_when_empty_R6: assert property (@(posedge clk) disable iff (!rst_n)
        s_ready |-> !dev_clk);

    assert_status_err_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(err_status) |-> (dev_config_n && !busy));

    assert_timeout_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(err_timeout) |-> !busy);
endmodule

bind pp_cfg_host pp_cfg_host_chk u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .start        (start),
    .dev_config_n (dev_config_n),
    .dev_clk      (dev_clk),
    .dev_data     (dev_data),
    .s_ready      (s_ready),
    .busy         (busy),
    .err_status   (err_status),
    .err_timeout  (err_timeout),
    .stat_s       (stat_s)
);

// File: tb/pp_cfg_host_bench.sv
module pp_cfg_host_bench;
    localparam int PULSE = 8;
    localparam int POR   = 6;
    localparam int LIMIT = 150000;

    localparam int M_IDLE = 0, M_PULSE = 1, M_WST = 2, M_STREAM = 3,
                   M_TAIL = 4, M_WINIT = 5, M_DONE = 6;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start = 1'b0, wait_init = 1'b0;
    logic [7:0] half_period = 8'd1;
    logic [15:0] tmo_limit = 16'd10;
    logic       s_valid = 1'b0, s_last = 1'b0;
    logic [7:0] s_data = 8'd0;
    logic       s_ready, dev_config_n, dev_clk, busy, done, err_status, err_timeout;
    logic [7:0] dev_data;
    logic       status_n = 1'b1, cfg_done = 1'b0, init_done = 1'b0;

    int checks = 0, errors = 0, cyc = 0;

    pp_cfg_host u_pp_cfg_host (
        .clk(clk), .rst_n(rst_n), .start(start), .wait_init(wait_init),
        .half_period(half_period), .tmo_limit(tmo_limit),
        .s_valid(s_valid), .s_data(s_data), .s_last(s_last), .s_ready(s_ready),
        .dev_config_n(dev_config_n), .dev_clk(dev_clk), .dev_data(dev_data),
        .dev_status_n(status_n), .dev_cfg_done(cfg_done), .dev_init_done(init_done),
        .busy(busy), .done(done), .err_status(err_status), .err_timeout(err_timeout)
    );

    always #5 clk = ~clk;

    task automatic chk(string req, string what, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // ---------------- reference model (updated on each rising edge)
    int ms = M_IDLE, mpc = 0, midx = 0, mtcnt = 0, mtmo = 0, mcnt = 0;
    bit mhave = 0, mlast = 0, mseen = 0, merrs = 0, merrt = 0, mwi = 0, mlvl = 0;
    bit ss1 = 0, ss2 = 0, cd1 = 0, cd2 = 0, id1 = 0, id2 = 0;
    int mdata = 0;

    always @(posedge clk) begin : ref_model
        bit run, fall, old_seen;
        int hh;
        if (!rst_n) begin
            ms = M_IDLE; mpc = 0; midx = 0; mtcnt = 0; mtmo = 0; mcnt = 0;
            mhave = 0; mlast = 0; mseen = 0; merrs = 0; merrt = 0; mwi = 0; mlvl = 0;
            ss1 = 0; ss2 = 0; cd1 = 0; cd2 = 0; id1 = 0; id2 = 0; mdata = 0;
        end else begin
            hh = (half_period < 1) ? 1 : int'(half_period);
            run = ((ms == M_STREAM && mhave) || ms == M_TAIL) && ss2;
            fall = run && mlvl && (mcnt == hh - 1);
            old_seen = mseen;
            case (ms)
                M_IDLE, M_DONE: if (start) begin
                    ms = M_PULSE; mpc = 0; mhave = 0; midx = 0; mseen = 0;
                    mtcnt = 0; mtmo = 0; merrs = 0; merrt = 0; mwi = wait_init;
                end
                M_PULSE: if (mpc == PULSE - 1) ms = M_WST; else mpc++;
                M_WST: if (ss2) ms = M_STREAM;
                M_STREAM: begin
                    if (!ss2) begin ms = M_IDLE; merrs = 1; mhave = 0; end
                    else begin
                        if (cd2) mseen = 1;
                        if (!mhave && s_valid) begin
                            mhave = 1; mdata = s_data; mlast = s_last; midx = 0;
                        end else if (fall) begin
                            if (midx == 3) begin mhave = 0; if (mlast) ms = M_TAIL; end
                            else midx++;
                        end
                    end
                end
                M_TAIL: begin
                    if (!ss2) begin ms = M_IDLE; merrs = 1; end
                    else begin
                        if (cd2) mseen = 1;
                        if (fall) begin
                            if (old_seen) begin
                                if (mtcnt == 1) ms = mwi ? M_WINIT : M_DONE;
                                else mtcnt++;
                            end else if (mtmo == int'(tmo_limit) - 1) begin
                                merrt = 1; ms = M_IDLE;
                            end else mtmo++;
                        end
                    end
                end
                M_WINIT: if (id2) ms = M_DONE;
                default: ms = M_IDLE;
            endcase
            if (!run) begin mcnt = 0; mlvl = 0; end
            else if (mcnt == hh - 1) begin mcnt = 0; mlvl = !mlvl; end
            else mcnt++;
            ss2 = ss1; ss1 = status_n;
            cd2 = cd1; cd1 = cfg_done;
            id2 = id1; id1 = init_done;
        end
    end

    // ---------------- per-cycle comparison
    always @(negedge clk) begin
        if (rst_n) begin
            chk("R2", "dev_config_n", dev_config_n, ms != M_PULSE);
            chk("R5", "dev_clk", dev_clk, mlvl);
            chk("R4", "dev_data", dev_data, mdata);
            chk("R6", "s_ready", s_ready, (ms == M_STREAM) && !mhave && ss2);
            chk("R3", "busy", busy, (ms != M_IDLE) && (ms != M_DONE));
            chk("R8", "done", done, ms == M_DONE);
            chk("R9", "err_status", err_status, merrs);
            chk("R10", "err_timeout", err_timeout, merrt);
        end
    end

    // ---------------- stream source
    logic [7:0] src_q[$];
    bit stall_en = 0, taken = 0;

    always @(negedge clk) begin
        if (taken) begin s_valid = 0; taken = 0; end
        if (!s_valid && src_q.size() > 0 && !(stall_en && (cyc % 6) < 3)) begin
            s_valid = 1; s_data = src_q[0]; s_last = (src_q.size() == 1);
        end
        if (s_valid && s_ready) begin
            void'(src_q.pop_front());
            taken = 1;
        end
    end

    // ---------------- device model and pin monitors
    int rises = 0, por = 0, fault_at = 0, cd_after = 0, init_cnt = 0;
    int low_len = 0, last_pulse = 0, hi_len = 0, hi_bad = 0, r3_bad = 0, r6_bad = 0;
    bit pclk = 0, in_por = 0, watch_hi = 1;
    logic [7:0] cap[$];

    always @(negedge clk) begin
        cyc++;
        if (!dev_config_n) begin
            low_len++;
            status_n = 0; por = POR; in_por = 1; rises = 0;
            cfg_done = 0; init_done = 0; init_cnt = 0;
        end else begin
            if (low_len > 0) begin last_pulse = low_len; low_len = 0; end
            if (por > 0) begin por--; status_n = 0; end
            else begin
                in_por = 0;
                status_n = !(fault_at > 0 && rises >= fault_at);
            end
            if (dev_clk && !pclk) begin
                rises++;
                cap.push_back(dev_data);
                if (in_por) r3_bad++;
            end
            if (cd_after > 0 && rises >= cd_after) cfg_done = 1;
            if (cfg_done) begin
                init_cnt++;
                if (init_cnt >= 4) init_done = 1;
            end
        end
        if (dev_clk) hi_len++;
        else begin
            if (pclk && watch_hi && hi_len != int'(half_period)) hi_bad++;
            hi_len = 0;
        end
        if (s_ready && dev_clk) r6_bad++;
        pclk = dev_clk;
    end

    // ---------------- watchdog
    always @(negedge clk) begin
        if (cyc >= LIMIT) begin
            errors++;
            $display("FAIL watchdog: actual %0d expected < %0d cycles", cyc, LIMIT);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    // outcome: 0 done, 1 status error, 2 timeout
    task automatic run_load(int h, int nbytes, int seed, bit wi, int cda, int flt,
                            int tmo, bit stall, int outcome, string req);
        logic [7:0] exp_b[$];
        int outc;
        half_period = 8'(h); tmo_limit = 16'(tmo); wait_init = wi;
        cd_after = cda; fault_at = flt; stall_en = stall; watch_hi = (flt == 0);
        hi_bad = 0; r3_bad = 0; r6_bad = 0;
        cap.delete();
        for (int i = 0; i < nbytes; i++) begin
            exp_b.push_back(8'((seed * 37 + i * 11 + 5) & 255));
            src_q.push_back(exp_b[i]);
        end
        @(negedge clk); start = 1;
        @(negedge clk); start = 0;
        for (int i = 0; i < 40000; i++) begin
            @(negedge clk);
            if (done || err_status || err_timeout) break;
        end
        outc = done ? 0 : (err_status ? 1 : (err_timeout ? 2 : 3));
        chk(req, "outcome", outc, outcome);
        chk("R2", "request pulse length", last_pulse, PULSE);
        chk("R3", "rising edges during power-on hold", r3_bad, 0);
        chk("R6", "clock high while empty", r6_bad, 0);
        if (flt == 0) chk("R5", "high phase length errors", hi_bad, 0);
        if (outcome == 0) begin
            for (int i = 0; i < nbytes; i++)
                for (int k = 0; k < 4; k++)
                    chk("R4", "captured byte", (4*i+k < cap.size()) ? int'(cap[4*i+k]) : -1,
                        int'(exp_b[i]));
            if (wi) chk("R8", "init seen at done", init_done, 1);
            for (int i = 0; i < 12; i++) begin
                @(negedge clk);
                chk("R7", "clock parked after done", dev_clk, 0);
            end
        end
        @(negedge clk);
        src_q.delete(); s_valid = 0; taken = 0; fault_at = 0;
        repeat (3) @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk("R1", "reset dev_config_n", dev_config_n, 1);
        chk("R1", "reset dev_clk", dev_clk, 0);
        chk("R1", "reset dev_data", dev_data, 0);
        chk("R1", "reset s_ready", s_ready, 0);
        chk("R1", "reset busy", busy, 0);
        chk("R1", "reset done", done, 0);
        chk("R1", "reset errors", {err_status, err_timeout}, 0);
        rst_n = 1;
        repeat (2) @(negedge clk);
        // R7 R4: fast clock, no stalls, no init wait
        run_load(1, 3, 1, 0, 12, 0, 20, 0, 0, "R7");
        // R6 R8: slow clock, stalling source, wait for init
        run_load(3, 4, 2, 1, 16, 0, 20, 1, 0, "R8");
        // R9: status drops mid-stream
        run_load(2, 3, 3, 0, 12, 5, 20, 0, 1, "R9");
        // R10: accept flag never arrives
        run_load(1, 2, 4, 0, 0, 0, 5, 0, 2, "R10");
        // R11: clean load after the error runs
        run_load(2, 2, 5, 1, 8, 0, 20, 1, 0, "R11");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule